// File: doc/BRIEF.md
# Negate, Clear and Complement Unit

This block is the single-operand arithmetic slice of an integer execution unit. Each accepted request carries a 32-bit operand, a 2-bit operation code, a 2-bit operand size, the current condition flags and a flag that says whether the destination is in memory. The slice performs one of four operations at byte, word or long width:

- negate with extend (the X flag is subtracted as a borrow),
- clear,
- plain negate,
- bitwise complement.

One clock later it presents the registered result, the new condition flags, a write-enable for the destination, and the number of cycles the operation costs.

Bits above the selected width are not part of the arithmetic and are passed through from the operand. This lets a register-file write of the full word keep its upper bytes.

Negate-with-extend can only clear the zero flag and never set it. Software can therefore chain it across several words and read one Z flag that reflects the whole multi-word value.

A size code of 3 is illegal. Such a request is flagged, suppresses the write, and leaves the flags as they were.

Top module: `nccu_unit`

## Requirements
- R1: The operation code selects 0 = negate with extend, 1 = clear, 2 = negate, 3 = complement. The size code selects 0 = byte (8 bits), 1 = word (16 bits), 2 = long (32 bits). Both flag vectors are packed as bit 4 = X, bit 3 = N, bit 2 = Z, bit 1 = V, bit 0 = C.
- R2: Negate with extend produces (0 − operand − X) at the selected width. C is set when the operand's low bits or X are nonzero. V is set when the sign bits of both the operand and the result are 1. N is the result's sign bit. Z becomes 0 if the result is nonzero and otherwise keeps its incoming value.
- R3: Clear produces zero in the selected width and sets N=0, Z=1, V=0, C=0, whatever the operand holds.
- R4: Negate produces (0 − operand) at the selected width. N is the sign bit. Z is set exactly when the result is zero. C is set when the operand is nonzero. V is set when the operand and the result both have the sign bit set.
- R5: Complement produces the bitwise inverse at the selected width. N and Z follow the result, and V and C are cleared.
- R6: For both negate forms, the new X equals the new C. Clear and complement return X unchanged.
- R7: Result bits above the selected width equal the corresponding operand bits.
- R8: The cycle count is 4 for byte and word and 6 for long, and it is doubled when the memory flag is set.
- R9: Size code 3 raises the illegal output and drops the write-enable. It returns the operand as the result, the incoming flags unchanged, and a cycle count of 0.
- R10: A request accepted with in_valid at a rising edge appears on the outputs after that edge, with out_valid high for exactly one cycle. A legal request raises wr_en.
- R11: While reset is held, out_valid, wr_en, illegal, the result, the flags and the cycle count are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| op_code | input | 2 | Operation select (R1) |
| op_size | input | 2 | Operand size (R1) |
| operand | input | 32 | Source and destination data |
| flags_in | input | 5 | Current flags {X,N,Z,V,C} |
| dst_mem | input | 1 | Destination is in memory |
| out_valid | output | 1 | Result strobe |
| result | output | 32 | Value to write back |
| flags_out | output | 5 | New flags {X,N,Z,V,C} |
| wr_en | output | 1 | Destination write enable |
| cycles | output | 5 | Cycle cost of the operation |
| illegal | output | 1 | Size code 3 rejected |

## Verification
The bench targets the sticky zero of negate-with-extend in three cases:
- a zero result with Z already clear, where a design that computes Z afresh would wrongly set it;
- a zero operand with X set, where the wrap to all ones must also raise C and X;
- a zero result with Z set, which must stay set.

The most negative value at each width must raise V and C together; a design that takes V from the carry chain alone misses this case. Operands carry distinct patterns in their upper bytes, so a design that zeroes or sign-extends past the selected width changes the written result. Illegal size codes and memory destinations check that the write is dropped and that the cycle count is doubled.

// File: rtl/nccu_pkg.sv
package nccu_pkg;

   typedef enum logic [1:0] {
      OP_NEGX = 2'd0,
      OP_CLR  = 2'd1,
      OP_NEG  = 2'd2,
      OP_NOT  = 2'd3
   } nccu_op_e;

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam logic [1:0] SZ_WORD = 2'd1;
   localparam logic [1:0] SZ_LONG = 2'd2;
   localparam logic [1:0] SZ_BAD  = 2'd3;

   localparam int FLAG_W = 5;
   localparam int FX = 4;
   localparam int FN = 3;
   localparam int FZ = 2;
   localparam int FV = 1;
   localparam int FC = 0;

   typedef struct packed {
      logic x;
      logic n;
      logic z;
      logic v;
      logic c;
   } nccu_flags_t;

endpackage

// File: rtl/nccu_lane.sv
// One width lane: computes the three candidate results for a fixed width
// and carries the operand bits above that width through unchanged.
module nccu_lane #(
   parameter int DATA_W = 32,
   parameter int LANE_W = 8
) (
   input  logic [DATA_W-1:0] a,
   input  logic              borrow_in,
   output logic [DATA_W-1:0] neg_res,
   output logic [DATA_W-1:0] not_res,
   output logic [DATA_W-1:0] clr_res,
   output logic              borrow_out,
   output logic              a_sign
);

   if (LANE_W < 1 || LANE_W > DATA_W) begin : g_bad_lane
      $error("nccu_lane: LANE_W must be within 1..DATA_W");
   end

   logic [LANE_W:0] diff;

   assign diff       = {1'b0, {LANE_W{1'b0}}} - {1'b0, a[LANE_W-1:0]}
                       - {{LANE_W{1'b0}}, borrow_in};
   assign borrow_out = diff[LANE_W];
   assign a_sign     = a[LANE_W-1];

   if (LANE_W < DATA_W) begin : g_pass
      assign neg_res = {a[DATA_W-1:LANE_W], diff[LANE_W-1:0]};
      assign not_res = {a[DATA_W-1:LANE_W], ~a[LANE_W-1:0]};
      assign clr_res = {a[DATA_W-1:LANE_W], {LANE_W{1'b0}}};
   end else begin : g_full
      assign neg_res = diff[LANE_W-1:0];
      assign not_res = ~a;
      assign clr_res = '0;
   end

endmodule

// File: rtl/nccu_core.sv
// Combinational core: builds one lane per legal size and selects.
module nccu_core
   import nccu_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int LANES  = 3
) (
   input  logic [DATA_W-1:0] a,
   input  logic [1:0]        op,
   input  logic [1:0]        size,
   input  nccu_flags_t       fin,
   output logic [DATA_W-1:0] res,
   output nccu_flags_t       fout,
   output logic              bad_size
);

   if ((8 << (LANES - 1)) != DATA_W) begin : g_bad_core
      $error("nccu_core: widest lane must equal DATA_W");
   end

   logic [DATA_W-1:0] neg_r  [LANES];
   logic [DATA_W-1:0] not_r  [LANES];
   logic [DATA_W-1:0] clr_r  [LANES];
   logic [LANES-1:0]  brw;
   logic [LANES-1:0]  asg;
   logic [LANES-1:0]  rsg_neg;
   logic [LANES-1:0]  rsg_not;
   logic [LANES-1:0]  zero_neg;
   logic [LANES-1:0]  zero_not;
   logic              xb;

   assign xb = (op == OP_NEGX) ? fin.x : 1'b0;

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam int LW = 8 << g;
      nccu_lane #(.DATA_W(DATA_W), .LANE_W(LW)) u_lane (
         .a          (a),
         .borrow_in  (xb),
         .neg_res    (neg_r[g]),
         .not_res    (not_r[g]),
         .clr_res    (clr_r[g]),
         .borrow_out (brw[g]),
         .a_sign     (asg[g])
      );
      assign rsg_neg[g]  = neg_r[g][LW-1];
      assign rsg_not[g]  = not_r[g][LW-1];
      assign zero_neg[g] = (neg_r[g][LW-1:0] == '0);
      assign zero_not[g] = (not_r[g][LW-1:0] == '0);
   end

   always_comb begin
      int unsigned sel;
      sel      = 0;
      bad_size = (size == SZ_BAD);
      res      = a;
      fout     = fin;
      case (size)
         SZ_WORD: sel = 1;
         SZ_LONG: sel = 2;
         default: sel = 0;
      endcase
      if (!bad_size) begin
         case (nccu_op_e'(op))
            OP_NEGX, OP_NEG: begin
               res    = neg_r[sel];
               fout.n = rsg_neg[sel];
               fout.v = asg[sel] & rsg_neg[sel];
               fout.c = brw[sel];
               fout.x = brw[sel];
               fout.z = (op == OP_NEGX) ? (fin.z & zero_neg[sel]) : zero_neg[sel];
            end
            OP_CLR: begin
               res    = clr_r[sel];
               fout.n = 1'b0;
               fout.z = 1'b1;
               fout.v = 1'b0;
               fout.c = 1'b0;
            end
            default: begin
               res    = not_r[sel];
               fout.n = rsg_not[sel];
               fout.z = zero_not[sel];
               fout.v = 1'b0;
               fout.c = 1'b0;
            end
         endcase
      end
   end

endmodule

// File: rtl/nccu_cost.sv
// Cycle cost of an operation from its size and destination kind.
module nccu_cost #(
   parameter int CYC_W      = 5,
   parameter int COST_SHORT = 4,
   parameter int COST_LONG  = 6
) (
   input  logic [1:0]       size,
   input  logic             mem,
   input  logic             bad,
   output logic [CYC_W-1:0] cyc
);

   localparam int MAX_COST = 2 * ((COST_LONG > COST_SHORT) ? COST_LONG : COST_SHORT);

   if (MAX_COST >= (1 << CYC_W)) begin : g_bad_cost
      $error("nccu_cost: CYC_W too narrow for doubled cost");
   end

   logic [CYC_W-1:0] base;

   assign base = (size == 2'd2) ? CYC_W'(COST_LONG) : CYC_W'(COST_SHORT);
   assign cyc  = bad ? '0 : (mem ? (base << 1) : base);

endmodule

// File: rtl/nccu_unit.sv
module nccu_unit
   import nccu_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int CYC_W      = 5,
   parameter int COST_SHORT = 4,
   parameter int COST_LONG  = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        op_code,
   input  logic [1:0]        op_size,
   input  logic [DATA_W-1:0] operand,
   input  logic [4:0]        flags_in,
   input  logic              dst_mem,
   output logic              out_valid,
   output logic [DATA_W-1:0] result,
   output logic [4:0]        flags_out,
   output logic              wr_en,
   output logic [CYC_W-1:0]  cycles,
   output logic              illegal
);

   localparam int LANES = 3;

   if (DATA_W != 32) begin : g_bad_width
      $error("nccu_unit: DATA_W must be 32 (byte, word and long lanes)");
   end

   logic [DATA_W-1:0] c_res;
   nccu_flags_t       c_flags;
   logic              c_bad;
   logic [CYC_W-1:0]  c_cyc;

   nccu_core #(.DATA_W(DATA_W), .LANES(LANES)) u_core (
      .a        (operand),
      .op       (op_code),
      .size     (op_size),
      .fin      (nccu_flags_t'(flags_in)),
      .res      (c_res),
      .fout     (c_flags),
      .bad_size (c_bad)
   );

   nccu_cost #(.CYC_W(CYC_W), .COST_SHORT(COST_SHORT), .COST_LONG(COST_LONG)) u_cost (
      .size (op_size),
      .mem  (dst_mem),
      .bad  (c_bad),
      .cyc  (c_cyc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         result    <= '0;
         flags_out <= '0;
         wr_en     <= 1'b0;
         cycles    <= '0;
         illegal   <= 1'b0;
      end else begin
         out_valid <= in_valid;
         wr_en     <= in_valid & ~c_bad;
         illegal   <= in_valid & c_bad;
         if (in_valid) begin
            result    <= c_res;
            flags_out <= c_flags;
            cycles    <= c_cyc;
         end
      end
   end

endmodule

// File: rtl/nccu_unit_chk.sv
module nccu_unit_chk #(
   parameter int DATA_W = 32,
   parameter int CYC_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [1:0]        op_code,
   input logic [1:0]        op_size,
   input logic [DATA_W-1:0] operand,
   input logic [4:0]        flags_in,
   input logic              dst_mem,
   input logic              out_valid,
   input logic [DATA_W-1:0] result,
   input logic [4:0]        flags_out,
   input logic              wr_en,
   input logic [CYC_W-1:0]  cycles,
   input logic              illegal
);

   logic legal_in;
   assign legal_in = in_valid && (op_size != 2'd3);

   p_clear_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
      legal_in && op_code == 2'd1 |=> flags_out[3:0] == 4'b0100);

   p_negx_z_sticky_r2: assert property (@(posedge clk) disable iff (!rst_n)
      legal_in && op_code == 2'd0 && !flags_in[2] |=> !flags_out[2]);

   p_not_vc_r5: assert property (@(posedge clk) disable iff (!rst_n)
      legal_in && op_code == 2'd3 |=> flags_out[1:0] == 2'b00);

   p_x_follows_c_r6: assert property (@(posedge clk) disable iff (!rst_n)
      legal_in && !op_code[0] |=> flags_out[4] == flags_out[0]);

   p_x_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
      legal_in && op_code[0] |=> flags_out[4] == $past(flags_in[4]));

   p_illegal_nowrite_r9: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && op_size == 2'd3 |=> illegal && !wr_en && flags_out == $past(flags_in));

   p_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);

   p_no_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid && !wr_en && !illegal);

   p_cost_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
      legal_in |=> (cycles == 4 || cycles == 6 || cycles == 8 || cycles == 12));

endmodule

bind nccu_unit nccu_unit_chk #(.DATA_W(DATA_W), .CYC_W(CYC_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .op_code   (op_code),
   .op_size   (op_size),
   .operand   (operand),
   .flags_in  (flags_in),
   .dst_mem   (dst_mem),
   .out_valid (out_valid),
   .result    (result),
   .flags_out (flags_out),
   .wr_en     (wr_en),
   .cycles    (cycles),
   .illegal   (illegal)
);

// File: tb/sim_nccu_unit.sv
`timescale 1ns/1ps
module sim_nccu_unit;

   typedef struct {
      logic [31:0] res;
      logic [4:0]  fl;
      logic        we;
      logic [4:0]  cyc;
      logic        ill;
      string       tag;
   } exp_t;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        in_valid = 0;
   logic [1:0]  op_code = 0;
   logic [1:0]  op_size = 0;
   logic [31:0] operand = 0;
   logic [4:0]  flags_in = 0;
   logic        dst_mem = 0;
   logic        out_valid;
   logic [31:0] result;
   logic [4:0]  flags_out;
   logic        wr_en;
   logic [4:0]  cycles;
   logic        illegal;

   int checks = 0;
   int failures = 0;
   bit done = 0;
   exp_t sb[$];

   always #5 clk = ~clk;

   nccu_unit u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
      .op_size(op_size), .operand(operand), .flags_in(flags_in), .dst_mem(dst_mem),
      .out_valid(out_valid), .result(result), .flags_out(flags_out), .wr_en(wr_en),
      .cycles(cycles), .illegal(illegal)
   );

   task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic exp_t model(input logic [1:0] op, input logic [1:0] sz, input logic [31:0] a,
                                  input logic [4:0] fl, input logic mem, input string tag);
      exp_t e;
      longint unsigned mask, msb, low, t, r;
      int w;
      e.tag = tag;
      if (sz == 2'd3) begin
         e.res = a; e.fl = fl; e.we = 0; e.cyc = 0; e.ill = 1;
         return e;
      end
      w    = 8 << sz;
      mask = (64'd1 << w) - 1;
      msb  = 64'd1 << (w - 1);
      low  = {32'd0, a} & mask;
      e.fl = fl;
      case (op)
         2'd0, 2'd2: begin
            t = low + ((op == 2'd0) ? longint'(fl[4]) : 0);
            r = (64'd0 - t) & mask;
            e.fl[0] = (t != 0);
            e.fl[4] = (t != 0);
            e.fl[1] = ((low & msb) != 0) && ((r & msb) != 0);
            e.fl[3] = (r & msb) != 0;
            e.fl[2] = (op == 2'd0) ? (fl[2] && r == 0) : (r == 0);
         end
         2'd1: begin
            r = 0;
            e.fl[3:0] = 4'b0100;
         end
         default: begin
            r = (~low) & mask;
            e.fl[3] = (r & msb) != 0;
            e.fl[2] = (r == 0);
            e.fl[1:0] = 2'b00;
         end
      endcase
      e.res = (a & ~mask[31:0]) | r[31:0];
      e.we  = 1;
      e.ill = 0;
      e.cyc = ((sz == 2'd2) ? 5'd6 : 5'd4) * (mem ? 5'd2 : 5'd1);
      return e;
   endfunction

   task automatic drive(input logic [1:0] op, input logic [1:0] sz, input logic [31:0] a,
                        input logic [4:0] fl, input logic mem, input string tag);
      @(negedge clk);
      in_valid = 1; op_code = op; op_size = sz; operand = a; flags_in = fl; dst_mem = mem;
      sb.push_back(model(op, sz, a, fl, mem, tag));
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = 0;
   endtask

   // monitor: results appear the cycle after the request edge (R10)
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         exp_t e;
         if (sb.size() == 0) begin
            chk("R10", "unexpected out_valid", 1, 0);
         end else begin
            e = sb.pop_front();
            chk(e.tag, "result", result, e.res);
            chk(e.tag, "flags", {27'd0, flags_out}, {27'd0, e.fl});
            chk(e.tag, "wr_en", {31'd0, wr_en}, {31'd0, e.we});
            chk(e.tag, "cycles", {27'd0, cycles}, {27'd0, e.cyc});
            chk(e.tag, "illegal", {31'd0, illegal}, {31'd0, e.ill});
         end
      end
   end

   initial begin
      #(200000 * 10);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] seed;
      repeat (3) @(negedge clk);
      // R11 reset state
      chk("R11", "out_valid", {31'd0, out_valid}, 0);
      chk("R11", "result", result, 0);
      chk("R11", "flags", {27'd0, flags_out}, 0);
      chk("R11", "wr_en/illegal/cycles", {25'd0, wr_en, illegal, cycles}, 0);
      rst_n = 1;

      // R2 negate with extend corners
      drive(2'd0, 2'd0, 32'h0000_0000, 5'b00100, 0, "R2_zero_keepz");
      drive(2'd0, 2'd0, 32'h0000_0000, 5'b00000, 0, "R2_zero_z_stays_clear");
      drive(2'd0, 2'd0, 32'h1234_5600, 5'b10100, 0, "R2_x_wraps");
      drive(2'd0, 2'd1, 32'h0000_8000, 5'b00100, 1, "R2_word_min");
      drive(2'd0, 2'd2, 32'h7FFF_FFFF, 5'b10000, 0, "R2_long_x_to_min");
      // R4 negate
      drive(2'd2, 2'd1, 32'hABCD_8000, 5'b10000, 0, "R4_word_min_v");
      drive(2'd2, 2'd2, 32'h0000_0000, 5'b10011, 1, "R4_long_zero");
      drive(2'd2, 2'd0, 32'hABCD_EF01, 5'b00000, 0, "R7_byte_upper_pass");
      drive(2'd2, 2'd0, 32'h0000_0080, 5'b00100, 0, "R4_byte_min");
      // R3 clear
      drive(2'd1, 2'd2, 32'hDEAD_BEEF, 5'b11011, 1, "R3_long_mem");
      drive(2'd1, 2'd0, 32'hDEAD_BEEF, 5'b01001, 0, "R3_R7_byte");
      // R5 complement
      drive(2'd3, 2'd1, 32'h5555_FFFF, 5'b10011, 0, "R5_word_zero");
      drive(2'd3, 2'd2, 32'h0F0F_0F0F, 5'b00000, 1, "R5_long");
      // R9 illegal size
      drive(2'd2, 2'd3, 32'h0000_0001, 5'b10101, 0, "R9_illegal");
      drive(2'd1, 2'd3, 32'hFFFF_0000, 5'b01010, 1, "R9_illegal_clr");
      idle();
      idle();
      // R1 R6 R8: sweep of codes and sizes
      seed = 32'h1357_9BDF;
      for (int i = 0; i < 64; i++) begin
         seed = seed * 32'd1664525 + 32'd1013904223;
         drive(i[1:0], i[3:2] % 3, seed ^ {seed[15:0], seed[31:16]}, seed[4:0], i[4],
               "R1_R6_R8_sweep");
      end
      idle();
      repeat (3) @(negedge clk);
      chk("R10", "scoreboard drained", sb.size(), 0);
      chk("R10", "out_valid idle", {31'd0, out_valid}, 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule